// File: doc/BRIEF.md
# Mode-Switchable 8/16-bit Arithmetic and Logic Unit

This block is the arithmetic and logic stage of an accumulator-based processor. Each valid request carries an operation code, the accumulator value, a memory operand, the incoming N, V, Z and C status bits, a width-mode bit and an immediate-mode bit. One clock later the unit returns a result word, a write strobe that names its destination (accumulator or memory), and the next value of each of the four status bits. A status bit that the operation does not touch comes back equal to its input.

In 16-bit mode all operand bits take part, and the sign and overflow positions are bits 15 and 14. In 8-bit mode only the low byte is computed and bits 7 and 6 supply the sign and overflow positions. The upper byte of the destination passes through unchanged. Read-modify-write operations (shifts, rotates, increment and decrement) act on either the accumulator or the memory operand, chosen by a select input. Decimal arithmetic, address generation and instruction decode are handled elsewhere.

Top module: `mwalu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, acc_we and mem_we are 0.
- R2: Add (op_code 0) writes A + M + C to the accumulator. C becomes the carry out of the active top bit, so 0xFFFF+1 in 16-bit mode gives 0x0000 with C=1 and Z=1. N and Z follow the result.
- R3: Subtract (op_code 1) writes A + NOT M + C. Compare (op_code 2) forms A - M with no write strobe and no change to V. For both, C=1 exactly when there is no unsigned borrow, and N and Z follow the difference.
- R4: For add and subtract, V=1 when the two addends (the operand inverted for subtract) share a sign and the result's sign differs. The sign is bit 15 in 16-bit mode and bit 7 in 8-bit mode.
- R5: AND (3), OR (4), XOR (5) and load (6) write A&M, A|M, A^M or M to the accumulator, update only N and Z, and return V and C unchanged.
- R6: Bit test (7) writes nothing and sets Z from A AND M. When imm_mode=0 it also copies N and V from the operand's top two active bits. When imm_mode=1, N and V are unchanged.
- R7: Test-and-set (8) writes A|M to memory and test-and-reset (9) writes (NOT A)&M to memory. Both set Z from A AND M and keep N, V and C.
- R8: Store (10) writes A to memory and store-zero (11) writes 0 to memory. Neither changes any status bit.
- R9: Shift-left (12) and rotate-left (14) take C from the old top active bit. Shift-left fills bit 0 with 0 and rotate-left fills it with C. Shift-right (13) and rotate-right (15) take C from bit 0. Shift-right fills the top active bit with 0, which clears N, and rotate-right fills it with C.
- R10: Increment (16) and decrement (17) wrap within the active width, update N and Z, and keep V and C.
- R11: With wide_mode=0, the result's upper byte equals the destination's incoming upper byte, and no carry reaches it.
- R12: Results appear exactly one cycle after the request. out_valid is in_valid delayed by one cycle.
- R13: For op_codes 12-17, rmw_mem=1 takes the operand from mem_in and raises mem_we. rmw_mem=0 uses acc_in and raises acc_we. When nothing is written, result equals acc_in. Op_codes 18-31 write nothing and keep every status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 5 | Operation select |
| wide_mode | input | 1 | 1 = 16-bit operands, 0 = 8-bit |
| imm_mode | input | 1 | Bit-test operand is an immediate |
| rmw_mem | input | 1 | Shift/inc/dec act on memory instead of accumulator |
| acc_in | input | 16 | Accumulator value |
| mem_in | input | 16 | Memory operand |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| z_in | input | 1 | Incoming zero flag |
| c_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Result word |
| acc_we | output | 1 | Write result to accumulator |
| mem_we | output | 1 | Write result to memory |
| n_out | output | 1 | Next negative flag |
| v_out | output | 1 | Next overflow flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |

## Verification
In 8-bit mode, a carry out of bit 7 and the preservation of the upper byte happen in the same result. The bench sets this up with an 8-bit add of 0x12FF and 0x0001. It expects 0x1200 with C=1 and Z=1, which shows the carry went to C and not into the upper byte. A shift of a memory operand whose upper byte is non-zero checks the same pairing for the memory destination. Every request is also scored against an independent integer model, and the expected results are queued with the cycle in which they are due.

// File: rtl/mwalu_pkg.sv
package mwalu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADC = 5'd0,
      OP_SBC = 5'd1,
      OP_CMP = 5'd2,
      OP_AND = 5'd3,
      OP_ORA = 5'd4,
      OP_EOR = 5'd5,
      OP_LDA = 5'd6,
      OP_BIT = 5'd7,
      OP_TSB = 5'd8,
      OP_TRB = 5'd9,
      OP_STA = 5'd10,
      OP_STZ = 5'd11,
      OP_ASL = 5'd12,
      OP_LSR = 5'd13,
      OP_ROL = 5'd14,
      OP_ROR = 5'd15,
      OP_INC = 5'd16,
      OP_DEC = 5'd17
   } alu_op_e;

   typedef struct packed {
      logic acc_we;
      logic mem_we;
      logic n;
      logic v;
      logic z;
      logic c;
   } alu_ctl_t;

endpackage

// File: rtl/mwalu_addsub.sv
module mwalu_addsub #(
   parameter int LANE_W = 8
) (
   input  logic [2*LANE_W-1:0] a,
   input  logic [2*LANE_W-1:0] b,
   input  logic                cin,
   input  logic                wide,
   output logic [2*LANE_W-1:0] sum,
   output logic                cout,
   output logic                ovf
);
   localparam int DW = 2 * LANE_W;

   logic [LANE_W:0] lo_lane;
   logic [LANE_W:0] hi_lane;
   logic            sa, sb, sr;

   always_comb begin
      lo_lane = {1'b0, a[LANE_W-1:0]} + {1'b0, b[LANE_W-1:0]} + {{LANE_W{1'b0}}, cin};
      hi_lane = {1'b0, a[DW-1:LANE_W]} + {1'b0, b[DW-1:LANE_W]}
              + {{LANE_W{1'b0}}, lo_lane[LANE_W]};
      if (wide) begin
         sum  = {hi_lane[LANE_W-1:0], lo_lane[LANE_W-1:0]};
         cout = hi_lane[LANE_W];
         sa   = a[DW-1];
         sb   = b[DW-1];
         sr   = hi_lane[LANE_W-1];
      end else begin
         sum  = {a[DW-1:LANE_W], lo_lane[LANE_W-1:0]};
         cout = lo_lane[LANE_W];
         sa   = a[LANE_W-1];
         sb   = b[LANE_W-1];
         sr   = lo_lane[LANE_W-1];
      end
      ovf = (sa == sb) && (sr != sa);
   end

endmodule

// File: rtl/mwalu_shifter.sv
module mwalu_shifter
   import mwalu_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic [2*LANE_W-1:0] x,
   input  logic                cin,
   input  logic                wide,
   input  alu_op_e             op,
   output logic [2*LANE_W-1:0] y,
   output logic                cout
);
   localparam int DW = 2 * LANE_W;

   logic msb;

   always_comb begin
      msb  = wide ? x[DW-1] : x[LANE_W-1];
      y    = x;
      cout = cin;
      case (op)
         OP_ASL: begin
            y    = x << 1;
            cout = msb;
         end
         OP_ROL: begin
            y    = {x[DW-2:0], cin};
            cout = msb;
         end
         OP_LSR: begin
            y = x >> 1;
            if (!wide) y[LANE_W-1] = 1'b0;
            cout = x[0];
         end
         OP_ROR: begin
            y = x >> 1;
            if (wide) y[DW-1] = cin;
            else      y[LANE_W-1] = cin;
            cout = x[0];
         end
         OP_INC:  y = x + DW'(1);
         OP_DEC:  y = x - DW'(1);
         default: y = x;
      endcase
   end

endmodule

// File: rtl/mwalu_core.sv
module mwalu_core
   import mwalu_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  alu_op_e             op,
   input  logic                wide,
   input  logic                imm,
   input  logic                rmw_mem,
   input  logic [2*LANE_W-1:0] a,
   input  logic [2*LANE_W-1:0] m,
   input  logic                n_in,
   input  logic                v_in,
   input  logic                z_in,
   input  logic                c_in,
   output logic [2*LANE_W-1:0] res,
   output alu_ctl_t            ctl
);
   localparam int DW = 2 * LANE_W;

   function automatic logic sign_of(input logic [DW-1:0] v, input logic w);
      return w ? v[DW-1] : v[LANE_W-1];
   endfunction

   function automatic logic next_of(input logic [DW-1:0] v, input logic w);
      return w ? v[DW-2] : v[LANE_W-2];
   endfunction

   function automatic logic zero_of(input logic [DW-1:0] v, input logic w);
      return w ? (v == '0) : (v[LANE_W-1:0] == '0);
   endfunction

   logic            is_sub;
   logic [DW-1:0]   b_eff;
   logic            cin_eff;
   logic [DW-1:0]   sum;
   logic            add_c, add_v;
   logic [DW-1:0]   rmw_x;
   logic [DW-1:0]   rmw_y;
   logic            rmw_c;

   assign is_sub  = (op == OP_SBC) || (op == OP_CMP);
   assign b_eff   = is_sub ? ~m : m;
   assign cin_eff = (op == OP_CMP) ? 1'b1 : c_in;
   assign rmw_x   = rmw_mem ? m : a;

   mwalu_addsub #(.LANE_W(LANE_W)) u_addsub (
      .a    (a),
      .b    (b_eff),
      .cin  (cin_eff),
      .wide (wide),
      .sum  (sum),
      .cout (add_c),
      .ovf  (add_v)
   );

   mwalu_shifter #(.LANE_W(LANE_W)) u_shift (
      .x    (rmw_x),
      .cin  (c_in),
      .wide (wide),
      .op   (op),
      .y    (rmw_y),
      .cout (rmw_c)
   );

   logic [DW-1:0] raw;
   logic [DW-1:0] dest;
   logic          nz_upd;

   always_comb begin
      raw    = a;
      nz_upd = 1'b0;
      ctl    = '{acc_we: 1'b0, mem_we: 1'b0, n: n_in, v: v_in, z: z_in, c: c_in};
      case (op)
         OP_ADC, OP_SBC: begin
            raw        = sum;
            nz_upd     = 1'b1;
            ctl.acc_we = 1'b1;
            ctl.c      = add_c;
            ctl.v      = add_v;
         end
         OP_CMP: begin
            raw    = sum;
            nz_upd = 1'b1;
            ctl.c  = add_c;
         end
         OP_AND, OP_ORA, OP_EOR, OP_LDA: begin
            case (op)
               OP_AND:  raw = a & m;
               OP_ORA:  raw = a | m;
               OP_EOR:  raw = a ^ m;
               default: raw = m;
            endcase
            nz_upd     = 1'b1;
            ctl.acc_we = 1'b1;
         end
         OP_BIT: begin
            ctl.z = zero_of(a & m, wide);
            if (!imm) begin
               ctl.n = sign_of(m, wide);
               ctl.v = next_of(m, wide);
            end
         end
         OP_TSB, OP_TRB: begin
            raw        = (op == OP_TSB) ? (a | m) : (~a & m);
            ctl.mem_we = 1'b1;
            ctl.z      = zero_of(a & m, wide);
         end
         OP_STA: begin
            raw        = a;
            ctl.mem_we = 1'b1;
         end
         OP_STZ: begin
            raw        = '0;
            ctl.mem_we = 1'b1;
         end
         OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_INC, OP_DEC: begin
            raw        = rmw_y;
            nz_upd     = 1'b1;
            ctl.mem_we = rmw_mem;
            ctl.acc_we = !rmw_mem;
            if (op != OP_INC && op != OP_DEC) ctl.c = rmw_c;
         end
         default: raw = a;
      endcase
      if (nz_upd) begin
         ctl.n = sign_of(raw, wide);
         ctl.z = zero_of(raw, wide);
      end
   end

   always_comb begin
      dest = ctl.mem_we ? m : a;
      if (!ctl.acc_we && !ctl.mem_we) res = a;
      else if (wide)                  res = raw;
      else                            res = {dest[DW-1:LANE_W], raw[LANE_W-1:0]};
   end

endmodule

// File: rtl/mwalu.sv
module mwalu
   import mwalu_pkg::*;
#(
   parameter int LANE_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [OP_W-1:0]     op_code,
   input  logic                wide_mode,
   input  logic                imm_mode,
   input  logic                rmw_mem,
   input  logic [2*LANE_W-1:0] acc_in,
   input  logic [2*LANE_W-1:0] mem_in,
   input  logic                n_in,
   input  logic                v_in,
   input  logic                z_in,
   input  logic                c_in,
   output logic                out_valid,
   output logic [2*LANE_W-1:0] result,
   output logic                acc_we,
   output logic                mem_we,
   output logic                n_out,
   output logic                v_out,
   output logic                z_out,
   output logic                c_out
);
   localparam int DW = 2 * LANE_W;

   generate
      if (LANE_W < 4) begin : g_lane_too_small
         $error("mwalu: LANE_W must be at least 4");
      end
   endgenerate

   alu_op_e       op_e;
   logic [DW-1:0] nxt_res;
   alu_ctl_t      nxt_ctl;

   assign op_e = alu_op_e'(op_code);

   mwalu_core #(.LANE_W(LANE_W)) u_core (
      .op      (op_e),
      .wide    (wide_mode),
      .imm     (imm_mode),
      .rmw_mem (rmw_mem),
      .a       (acc_in),
      .m       (mem_in),
      .n_in    (n_in),
      .v_in    (v_in),
      .z_in    (z_in),
      .c_in    (c_in),
      .res     (nxt_res),
      .ctl     (nxt_ctl)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               result    <= '0;
               acc_we    <= 1'b0;
               mem_we    <= 1'b0;
               n_out     <= 1'b0;
               v_out     <= 1'b0;
               z_out     <= 1'b0;
               c_out     <= 1'b0;
            end else begin
               out_valid <= in_valid;
               result    <= nxt_res;
               acc_we    <= in_valid && nxt_ctl.acc_we;
               mem_we    <= in_valid && nxt_ctl.mem_we;
               n_out     <= nxt_ctl.n;
               v_out     <= nxt_ctl.v;
               z_out     <= nxt_ctl.z;
               c_out     <= nxt_ctl.c;
            end
         end

         // R12
         valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         // R12
         valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
      end else begin : g_comb
         assign out_valid = in_valid;
         assign result    = nxt_res;
         assign acc_we    = in_valid && nxt_ctl.acc_we;
         assign mem_we    = in_valid && nxt_ctl.mem_we;
         assign n_out     = nxt_ctl.n;
         assign v_out     = nxt_ctl.v;
         assign z_out     = nxt_ctl.z;
         assign c_out     = nxt_ctl.c;
      end
   endgenerate

   // R3
   cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_e == OP_CMP) |-> (!nxt_ctl.acc_we && !nxt_ctl.mem_we && nxt_ctl.v == v_in));
   // R5
   logic_cv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_e inside {OP_AND, OP_ORA, OP_EOR, OP_LDA}) |-> (nxt_ctl.c == c_in && nxt_ctl.v == v_in));
   // R8
   store_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_e inside {OP_STA, OP_STZ}) |->
      (nxt_ctl.n == n_in && nxt_ctl.v == v_in && nxt_ctl.z == z_in && nxt_ctl.c == c_in));
   // R9
   lsr_n_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_e == OP_LSR) |-> !nxt_ctl.n);
   // R10
   incdec_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_e inside {OP_INC, OP_DEC}) |-> (nxt_ctl.c == c_in && nxt_ctl.v == v_in));

endmodule

// File: tb/mwalu_test.sv
module mwalu_test;

   typedef struct {
      logic [15:0] res;
      logic        acc_we;
      logic        mem_we;
      logic        n, v, z, c;
      string       tag;
      int          due;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  op_code = '0;
   logic        wide_mode = 1'b0;
   logic        imm_mode = 1'b0;
   logic        rmw_mem = 1'b0;
   logic [15:0] acc_in = '0;
   logic [15:0] mem_in = '0;
   logic        n_in = 1'b0, v_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
   logic        out_valid;
   logic [15:0] result;
   logic        acc_we, mem_we, n_out, v_out, z_out, c_out;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   exp_t sb_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mwalu uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .wide_mode(wide_mode), .imm_mode(imm_mode), .rmw_mem(rmw_mem),
      .acc_in(acc_in), .mem_in(mem_in),
      .n_in(n_in), .v_in(v_in), .z_in(z_in), .c_in(c_in),
      .out_valid(out_valid), .result(result), .acc_we(acc_we), .mem_we(mem_we),
      .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out)
   );

   function automatic exp_t model(int op, bit w, logic [15:0] a, logic [15:0] m,
                                  bit n, bit v, bit z, bit c, bit imm, bit rmw);
      exp_t e;
      int mask = w ? 'hFFFF : 'hFF;
      int sg   = w ? 'h8000 : 'h80;
      int aa = int'(a) & mask;
      int mm = int'(m) & mask;
      int s, r, x, mi;
      bit wr = 0, tomem = 0, nz = 0;
      e.res = a; e.acc_we = 0; e.mem_we = 0;
      e.n = n; e.v = v; e.z = z; e.c = c;
      r = 0;
      x = rmw ? mm : aa;
      case (op)
         0, 1: begin
            mi = (op == 1) ? ((~mm) & mask) : mm;
            s = aa + mi + int'(c);
            r = s & mask;
            e.c = (s > mask);
            e.v = (((aa ^ r) & (mi ^ r) & sg) != 0);
            wr = 1; nz = 1;
         end
         2: begin r = (aa - mm) & mask; e.c = (aa >= mm); nz = 1; end
         3: begin r = aa & mm; wr = 1; nz = 1; end
         4: begin r = aa | mm; wr = 1; nz = 1; end
         5: begin r = aa ^ mm; wr = 1; nz = 1; end
         6: begin r = mm; wr = 1; nz = 1; end
         7: begin
            e.z = ((aa & mm) == 0);
            if (!imm) begin e.n = ((mm & sg) != 0); e.v = ((mm & (sg >> 1)) != 0); end
         end
         8: begin r = aa | mm; e.z = ((aa & mm) == 0); wr = 1; tomem = 1; end
         9: begin r = (~aa) & mm & mask; e.z = ((aa & mm) == 0); wr = 1; tomem = 1; end
         10: begin r = aa; wr = 1; tomem = 1; end
         11: begin r = 0; wr = 1; tomem = 1; end
         12: begin r = (x << 1) & mask; e.c = ((x & sg) != 0); end
         13: begin r = x >> 1; e.c = x[0]; end
         14: begin r = ((x << 1) | int'(c)) & mask; e.c = ((x & sg) != 0); end
         15: begin r = (x >> 1) | (c ? sg : 0); e.c = x[0]; end
         16: r = (x + 1) & mask;
         17: r = (x - 1) & mask;
         default: ;
      endcase
      if (op >= 12 && op <= 17) begin wr = 1; tomem = rmw; nz = 1; end
      if (nz) begin e.n = ((r & sg) != 0); e.z = (r == 0); end
      if (wr) begin
         e.res = 16'(((tomem ? int'(m) : int'(a)) & ~mask) | r);
         e.acc_we = !tomem;
         e.mem_we = tomem;
      end
      return e;
   endfunction

   task automatic issue(int op, bit w, logic [15:0] a, logic [15:0] m, bit [3:0] nvzc,
                        bit imm, bit rmw, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; op_code = 5'(op); wide_mode = w; imm_mode = imm; rmw_mem = rmw;
      acc_in = a; mem_in = m;
      {n_in, v_in, z_in, c_in} = nvzc;
      e = model(op, w, a, m, nvzc[3], nvzc[2], nvzc[1], nvzc[0], imm, rmw);
      e.tag = tag;
      e.due = cyc + 1;
      sb_q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: compares each result against the front of the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (sb_q.size() == 0) begin
            failures++;
            $display("FAIL R12 unexpected out_valid: actual=1 expected=0");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (result !== e.res || acc_we !== e.acc_we || mem_we !== e.mem_we ||
                n_out !== e.n || v_out !== e.v || z_out !== e.z || c_out !== e.c ||
                cyc != e.due) begin
               failures++;
               $display("FAIL %s: actual res=%h aw=%b mw=%b nvzc=%b%b%b%b cyc=%0d expected res=%h aw=%b mw=%b nvzc=%b%b%b%b cyc=%0d",
                        e.tag, result, acc_we, mem_we, n_out, v_out, z_out, c_out, cyc,
                        e.res, e.acc_we, e.mem_we, e.n, e.v, e.z, e.c, e.due);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (out_valid !== 1'b0 || acc_we !== 1'b0 || mem_we !== 1'b0) begin
         failures++;
         $display("FAIL R1: actual v/aw/mw=%b%b%b expected 000", out_valid, acc_we, mem_we);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || acc_we !== 1'b0 || mem_we !== 1'b0) begin
         failures++;
         $display("FAIL R1 post-reset: actual v/aw/mw=%b%b%b expected 000", out_valid, acc_we, mem_we);
      end

      issue(0, 1, 16'hFFFF, 16'h0001, 4'b0000, 0, 0, "R2 wide carry chain");
      issue(0, 0, 16'h12FF, 16'h0001, 4'b0000, 0, 0, "R11 narrow carry keeps high byte");
      issue(0, 1, 16'h7FFF, 16'h0001, 4'b0000, 0, 0, "R4 wide add overflow");
      issue(0, 0, 16'h007F, 16'h0001, 4'b0000, 0, 0, "R4 narrow add overflow");
      issue(1, 1, 16'h0005, 16'h0007, 4'b0001, 0, 0, "R3 wide subtract borrow");
      issue(1, 0, 16'hAB80, 16'h0001, 4'b0001, 0, 0, "R4 narrow subtract overflow");
      issue(2, 1, 16'h1234, 16'h1234, 4'b0100, 0, 0, "R3 compare equal");
      issue(2, 0, 16'h0010, 16'h0020, 4'b0000, 0, 0, "R3 compare less");
      idle();
      issue(3, 1, 16'hF0F0, 16'h0FF0, 4'b0101, 0, 0, "R5 and");
      issue(4, 0, 16'h5500, 16'h0080, 4'b0101, 0, 0, "R5 or narrow");
      issue(5, 1, 16'hAAAA, 16'hAAAA, 4'b0101, 0, 0, "R5 xor zero");
      issue(6, 1, 16'h9000, 16'h8001, 4'b0101, 0, 0, "R5 load");
      issue(7, 1, 16'h00FF, 16'h0000, 4'b1100, 1, 0, "R6 bit immediate");
      issue(7, 1, 16'h0001, 16'h4000, 4'b1000, 0, 0, "R6 bit wide");
      issue(7, 0, 16'h0001, 16'hFF81, 4'b0100, 0, 0, "R6 bit narrow");
      issue(8, 0, 16'h000F, 16'h77F0, 4'b1101, 0, 0, "R7 test-and-set");
      issue(9, 1, 16'h00FF, 16'h0F0F, 4'b1101, 0, 0, "R7 test-and-reset");
      issue(10, 0, 16'h3456, 16'hABCD, 4'b1111, 0, 0, "R8 store narrow");
      issue(11, 1, 16'h3456, 16'hABCD, 4'b0000, 0, 0, "R8 store zero");
      issue(12, 0, 16'h0000, 16'h3C80, 4'b0000, 0, 1, "R9 R13 shift-left memory");
      issue(13, 1, 16'h0001, 16'h0000, 4'b1000, 0, 0, "R9 shift-right clears N");
      issue(14, 1, 16'h8000, 16'h0000, 4'b0001, 0, 0, "R9 rotate-left");
      issue(15, 0, 16'h4400, 16'h0000, 4'b0001, 0, 0, "R9 rotate-right narrow");
      issue(16, 0, 16'h77FF, 16'h0000, 4'b0101, 0, 0, "R10 increment wrap");
      issue(17, 1, 16'h0000, 16'h0000, 4'b0100, 0, 0, "R10 decrement wrap");
      issue(16, 1, 16'h0000, 16'h7FFF, 4'b0000, 0, 1, "R13 increment memory");
      issue(25, 1, 16'hBEEF, 16'h1111, 4'b1010, 0, 0, "R13 undefined code");
      idle();
      idle();
      for (int i = 0; i < 400; i++) begin
         issue(int'($urandom_range(0, 17)), 1'($urandom), 16'($urandom), 16'($urandom),
               4'($urandom), 1'($urandom), 1'($urandom), "R11 sweep");
         if ((i % 7) == 3) idle();
      end
      idle();
      repeat (3) @(negedge clk);
      // R12 every issued item must have been returned
      checks++;
      if (sb_q.size() != 0) begin
         failures++;
         $display("FAIL R12 pending results: actual=%0d expected=0", sb_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule